// File: doc/BRIEF.md
# Threshold-Gated DMA Data FIFO

This block is the data buffer that sits between a serial engine and the system bus. Producers write bytes through a push port, and consumers take them through a pop port or through a DMA request/acknowledge handshake. The block reports its current fill level on a count output that is one bit wider than the pointers, so a completely full buffer can be shown. One instance serves one direction, either transmit or receive.

Illegal accesses are latched. A push into a full buffer is dropped and sets a sticky overflow flag. A pop from an empty buffer returns nothing and sets a sticky underflow flag. Both flags stay set until software writes a one to the flush control bit. That write also empties the buffer in a single cycle.

DMA requests are gated by two conditions: an enable bit and a programmable fill threshold. The request is raised only while the enable bit is set, the buffer holds at least one entry, and the fill level is at or above the threshold.

Top module: `dma_gated_fifo`

## Requirements
- R1: After reset, avail_cnt is 0, ovf_flag and unf_flag are 0, dma_req is 0 and pop_valid is 0.
- R2: Accepted pushes come out in arrival order. avail_cnt goes up by one per accepted push and down by one per accepted pop, and it reaches 32 when the buffer is full. Pop data appears on pop_data with pop_valid high in the cycle after the pop.
- R3: A push while avail_cnt is 32 is dropped and sets ovf_flag. The count and the stored contents do not change.
- R4: A pop (pop_req or dma_ack) while avail_cnt is 0 sets unf_flag. pop_valid stays 0 and the count does not change.
- R5: Once set, ovf_flag and unf_flag stay set until a flush, whatever other traffic occurs.
- R6: A cycle with ctl_wr=1 and ctl_flush=1 returns the count, both pointers and both flags to 0 on the next edge. A cycle with ctl_wr=1 and ctl_flush=0 has no effect.
- R7: A flush takes priority over a push or pop in the same cycle. The push is not stored and the pop returns no data.
- R8: dma_req is 0 whenever cfg_dma_en is 0.
- R9: dma_req is 1 exactly when cfg_dma_en=1, avail_cnt≥cfg_thresh and avail_cnt≠0. After an acknowledge that takes the count below the threshold, dma_req is low from the following cycle.
- R10: Each cycle with dma_ack high removes exactly one entry and delivers it on pop_data.
- R11: A push and a pop in the same cycle, with the buffer neither empty nor full, leave avail_cnt unchanged and keep FIFO order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| push_valid | input | 1 | Push request |
| push_data | input | 8 | Data to push |
| pop_req | input | 1 | Pop request from a register read |
| pop_valid | output | 1 | pop_data holds a freshly popped entry |
| pop_data | output | 8 | Popped data |
| ctl_wr | input | 1 | Control register write strobe |
| ctl_flush | input | 1 | Flush bit of the control write (write-one) |
| cfg_dma_en | input | 1 | DMA request enable |
| cfg_thresh | input | 5 | DMA fill threshold |
| avail_cnt | output | 6 | Number of stored entries |
| ovf_flag | output | 1 | Sticky overflow flag |
| unf_flag | output | 1 | Sticky underflow flag |
| dma_req | output | 1 | DMA request |
| dma_ack | input | 1 | DMA acknowledge; removes one entry |

## Verification
Some properties are checked by assertions on every cycle:
- the enable gating of the request and the threshold bound on it;
- the count never exceeding the depth;
- flag stickiness and the setting of a flag on an illegal access;
- the flush emptying the buffer;
- count stability under a simultaneous push and pop.

Other behaviour only the bench scenarios can show. These are data ordering across wrap-around, the contents surviving a dropped push, and flush winning over a same-cycle push. They also include the exact request level at every threshold and fill combination, which is swept exhaustively.

// File: rtl/dgf_pkg.sv
package dgf_pkg;
    // Classification of the accepted traffic in one cycle.
    typedef enum logic [1:0] {
        OP_IDLE = 2'b00,
        OP_PUSH = 2'b01,
        OP_POP  = 2'b10,
        OP_BOTH = 2'b11
    } fifo_op_e;
endpackage

// File: rtl/dgf_mem.sv
module dgf_mem #(
    parameter int DATA_W = 8,
    parameter int DEPTH  = 32,
    parameter int PTR_W  = 5
) (
    input  logic              clk,
    input  logic              wr_en,
    input  logic [PTR_W-1:0]  wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              rd_en,
    input  logic [PTR_W-1:0]  rd_addr,
    output logic [DATA_W-1:0] rd_data
);
    logic [DATA_W-1:0] store_q [DEPTH];
    logic [DATA_W-1:0] rd_data_q;

    always_ff @(posedge clk) begin
        if (wr_en) store_q[wr_addr] <= wr_data;
    end

    always_ff @(posedge clk) begin
        if (rd_en) rd_data_q <= store_q[rd_addr];
    end

    assign rd_data = rd_data_q;
endmodule

// File: rtl/dgf_dma_gate.sv
module dgf_dma_gate #(
    parameter int CNT_W = 6,
    parameter int THR_W = 5
) (
    input  logic             enable,
    input  logic [THR_W-1:0] thresh,
    input  logic [CNT_W-1:0] level,
    output logic             req
);
    logic [CNT_W-1:0] thresh_ext;

    assign thresh_ext = CNT_W'(thresh);
    // Never request on an empty buffer, even with a zero threshold.
    assign req = enable && (level != '0) && (level >= thresh_ext);
endmodule

// File: rtl/dma_gated_fifo.sv
module dma_gated_fifo #(
    parameter  int DATA_W = 8,
    parameter  int DEPTH  = 32,
    parameter  int THR_W  = 5,
    localparam int PTR_W  = $clog2(DEPTH),
    localparam int CNT_W  = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              push_valid,
    input  logic [DATA_W-1:0] push_data,
    input  logic              pop_req,
    output logic              pop_valid,
    output logic [DATA_W-1:0] pop_data,
    input  logic              ctl_wr,
    input  logic              ctl_flush,
    input  logic              cfg_dma_en,
    input  logic [THR_W-1:0]  cfg_thresh,
    output logic [CNT_W-1:0]  avail_cnt,
    output logic              ovf_flag,
    output logic              unf_flag,
    output logic              dma_req,
    input  logic              dma_ack
);
    import dgf_pkg::*;

    localparam logic [PTR_W-1:0] LAST_IDX = PTR_W'(DEPTH - 1);
    localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH);

    typedef struct packed {
        logic [PTR_W-1:0] wptr;
        logic [PTR_W-1:0] rptr;
        logic [CNT_W-1:0] cnt;
        logic             ovf;
        logic             unf;
        logic             rvalid;
    } ctl_t;

    ctl_t     st_d, st_q;
    logic     flush, pop_any, is_empty, is_full, push_ok, pop_ok;
    fifo_op_e op;

    function automatic logic [PTR_W-1:0] ptr_inc(input logic [PTR_W-1:0] p);
        return (p == LAST_IDX) ? '0 : p + PTR_W'(1);
    endfunction

    always_comb begin
        flush    = ctl_wr && ctl_flush;
        pop_any  = pop_req || dma_ack;
        is_empty = (st_q.cnt == '0);
        is_full  = (st_q.cnt == FULL_CNT);
        push_ok  = push_valid && !is_full && !flush;
        pop_ok   = pop_any && !is_empty && !flush;
        op       = fifo_op_e'({pop_ok, push_ok});

        st_d        = st_q;
        st_d.rvalid = pop_ok;
        if (flush) begin
            st_d.wptr = '0;
            st_d.rptr = '0;
            st_d.cnt  = '0;
            st_d.ovf  = 1'b0;
            st_d.unf  = 1'b0;
        end else begin
            if (push_valid && is_full) st_d.ovf = 1'b1;
            if (pop_any && is_empty)   st_d.unf = 1'b1;
            if (push_ok) st_d.wptr = ptr_inc(st_q.wptr);
            if (pop_ok)  st_d.rptr = ptr_inc(st_q.rptr);
            unique case (op)
                OP_PUSH: st_d.cnt = st_q.cnt + CNT_W'(1);
                OP_POP:  st_d.cnt = st_q.cnt - CNT_W'(1);
                default: st_d.cnt = st_q.cnt;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    dgf_mem #(
        .DATA_W (DATA_W),
        .DEPTH  (DEPTH),
        .PTR_W  (PTR_W)
    ) u_mem (
        .clk     (clk),
        .wr_en   (push_ok),
        .wr_addr (st_q.wptr),
        .wr_data (push_data),
        .rd_en   (pop_ok),
        .rd_addr (st_q.rptr),
        .rd_data (pop_data)
    );

    dgf_dma_gate #(
        .CNT_W (CNT_W),
        .THR_W (THR_W)
    ) u_gate (
        .enable (cfg_dma_en),
        .thresh (cfg_thresh),
        .level  (st_q.cnt),
        .req    (dma_req)
    );

    assign avail_cnt = st_q.cnt;
    assign ovf_flag  = st_q.ovf;
    assign unf_flag  = st_q.unf;
    assign pop_valid = st_q.rvalid;
endmodule

// File: rtl/dgf_checker.sv
module dgf_checker #(
    parameter int DEPTH = 32,
    parameter int THR_W = 5,
    parameter int CNT_W = 6
) (
    input logic             clk,
    input logic             rst_n,
    input logic             push_valid,
    input logic             pop_req,
    input logic             dma_ack,
    input logic             ctl_wr,
    input logic             ctl_flush,
    input logic             cfg_dma_en,
    input logic [THR_W-1:0] cfg_thresh,
    input logic [CNT_W-1:0] avail_cnt,
    input logic             ovf_flag,
    input logic             unf_flag,
    input logic             dma_req,
    input logic             pop_valid
);
    logic fl, pa;
    assign fl = ctl_wr && ctl_flush;
    assign pa = pop_req || dma_ack;

    assert_cnt_bound_R2: assert property (@(posedge clk) disable iff (!rst_n)
        avail_cnt <= CNT_W'(DEPTH));

    assert_ovf_set_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (push_valid && avail_cnt == CNT_W'(DEPTH) && !fl) |=> ovf_flag);

    assert_unf_set_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (pa && avail_cnt == '0 && !fl) |=> (unf_flag && !pop_valid));

    assert_sticky_ovf_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf_flag && !fl) |=> ovf_flag);

    assert_sticky_unf_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (unf_flag && !fl) |=> unf_flag);

    assert_flush_empty_R6: assert property (@(posedge clk) disable iff (!rst_n)
        fl |=> (avail_cnt == '0 && !ovf_flag && !unf_flag && !pop_valid));

    assert_req_enable_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_dma_en |-> !dma_req);

    assert_req_thresh_R9: assert property (@(posedge clk) disable iff (!rst_n)
        dma_req |-> (avail_cnt >= CNT_W'(cfg_thresh) && avail_cnt != '0));

    assert_both_stable_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (push_valid && pa && !fl && avail_cnt != '0 && avail_cnt != CNT_W'(DEPTH))
        |=> $stable(avail_cnt));
endmodule

bind dma_gated_fifo dgf_checker #(
    .DEPTH (DEPTH),
    .THR_W (THR_W),
    .CNT_W (CNT_W)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .push_valid (push_valid),
    .pop_req    (pop_req),
    .dma_ack    (dma_ack),
    .ctl_wr     (ctl_wr),
    .ctl_flush  (ctl_flush),
    .cfg_dma_en (cfg_dma_en),
    .cfg_thresh (cfg_thresh),
    .avail_cnt  (avail_cnt),
    .ovf_flag   (ovf_flag),
    .unf_flag   (unf_flag),
    .dma_req    (dma_req),
    .pop_valid  (pop_valid)
);

// File: tb/test_dma_gated_fifo.sv
`timescale 1ns/1ps
module test_dma_gated_fifo;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       push_valid = 1'b0;
    logic [7:0] push_data = '0;
    logic       pop_req = 1'b0;
    logic       pop_valid;
    logic [7:0] pop_data;
    logic       ctl_wr = 1'b0;
    logic       ctl_flush = 1'b0;
    logic       cfg_dma_en = 1'b0;
    logic [4:0] cfg_thresh = '0;
    logic [5:0] avail_cnt;
    logic       ovf_flag, unf_flag, dma_req;
    logic       dma_ack = 1'b0;

    int tests = 0;
    int fails = 0;
    bit done = 1'b0;
    int model[$];

    always #2.5 clk = ~clk;

    dma_gated_fifo i_dma_gated_fifo (
        .clk(clk), .rst_n(rst_n), .push_valid(push_valid), .push_data(push_data),
        .pop_req(pop_req), .pop_valid(pop_valid), .pop_data(pop_data),
        .ctl_wr(ctl_wr), .ctl_flush(ctl_flush), .cfg_dma_en(cfg_dma_en),
        .cfg_thresh(cfg_thresh), .avail_cnt(avail_cnt), .ovf_flag(ovf_flag),
        .unf_flag(unf_flag), .dma_req(dma_req), .dma_ack(dma_ack)
    );

    task automatic check(input string tag, input int act, input int exp);
        tests++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
        #0.5;
    endtask

    task automatic do_flush();
        ctl_wr = 1'b1; ctl_flush = 1'b1;
        step();
        ctl_wr = 1'b0; ctl_flush = 1'b0;
        model.delete();
    endtask

    task automatic push_one(input int v);
        push_valid = 1'b1; push_data = 8'(v);
        step();
        push_valid = 1'b0;
        model.push_back(v);
    endtask

    function automatic int pat(input int i);
        return (i * 37 + 11) % 256;
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #0.5;
        // R1 reset state
        check("R1 cnt", avail_cnt, 0);
        check("R1 ovf", ovf_flag, 0);
        check("R1 unf", unf_flag, 0);
        check("R1 req", dma_req, 0);
        check("R1 pop_valid", pop_valid, 0);

        // R4 pop on empty
        pop_req = 1'b1; step(); pop_req = 1'b0;
        check("R4 unf", unf_flag, 1);
        check("R4 pop_valid", pop_valid, 0);
        check("R4 cnt", avail_cnt, 0);
        // R5 stays set
        repeat (4) step();
        check("R5 unf sticky", unf_flag, 1);
        // R6 write of zero does nothing
        ctl_wr = 1'b1; ctl_flush = 1'b0; step(); ctl_wr = 1'b0;
        check("R6 zero write keeps unf", unf_flag, 1);
        do_flush();
        check("R6 flush clears unf", unf_flag, 0);

        // R2 fill to full, count each step
        for (int i = 0; i < 32; i++) begin
            push_one(pat(i));
            check("R2 fill cnt", avail_cnt, i + 1);
        end
        // R3 push while full dropped
        push_valid = 1'b1; push_data = 8'hAA; step(); push_valid = 1'b0;
        check("R3 ovf", ovf_flag, 1);
        check("R3 cnt", avail_cnt, 32);
        // R8 disabled request at full, zero threshold
        cfg_dma_en = 1'b0; cfg_thresh = '0; #0.5;
        check("R8 req off when disabled", dma_req, 0);
        // R2/R3 drain in order, contents intact
        for (int i = 0; i < 32; i++) begin
            pop_req = 1'b1; step(); pop_req = 1'b0;
            check("R2 pop_valid", pop_valid, 1);
            check("R3 data intact", pop_data, pat(i));
            check("R2 drain cnt", avail_cnt, 31 - i);
        end
        model.delete();
        check("R5 ovf sticky", ovf_flag, 1);
        check("R4 no unf on legal pops", unf_flag, 0);
        do_flush();
        check("R6 flush clears ovf", ovf_flag, 0);

        // R11 simultaneous push and pop, wrapping the pointers
        for (int i = 0; i < 3; i++) push_one(100 + i);
        for (int i = 0; i < 40; i++) begin
            int exp_v;
            exp_v = model.pop_front();
            push_valid = 1'b1; push_data = 8'(200 + i); pop_req = 1'b1;
            step();
            push_valid = 1'b0; pop_req = 1'b0;
            model.push_back((200 + i) % 256);
            check("R11 cnt stable", avail_cnt, 3);
            check("R11 order", pop_data, exp_v);
        end

        // R7 flush wins over push and pop
        do_flush();
        push_one(5);
        ctl_wr = 1'b1; ctl_flush = 1'b1; push_valid = 1'b1; push_data = 8'h77; pop_req = 1'b1;
        step();
        ctl_wr = 1'b0; ctl_flush = 1'b0; push_valid = 1'b0; pop_req = 1'b0;
        model.delete();
        check("R7 cnt", avail_cnt, 0);
        check("R7 no pop data", pop_valid, 0);
        step();
        check("R7 still empty", avail_cnt, 0);

        // R8/R9 exhaustive threshold x level sweep
        for (int t = 0; t < 32; t++) begin
            cfg_thresh = 5'(t);
            do_flush();
            for (int lvl = 0; lvl <= 32; lvl++) begin
                cfg_dma_en = 1'b1; #0.5;
                check("R9 req level", dma_req, (lvl >= t && lvl != 0) ? 1 : 0);
                cfg_dma_en = 1'b0; #0.5;
                check("R8 req gated", dma_req, 0);
                if (lvl < 32) push_one(lvl);
            end
        end

        // R9/R10 ack drops below threshold
        cfg_dma_en = 1'b1; cfg_thresh = 5'd4;
        do_flush();
        for (int i = 0; i < 4; i++) push_one(60 + i);
        check("R9 req at threshold", dma_req, 1);
        dma_ack = 1'b1; step(); dma_ack = 1'b0;
        check("R10 one entry moved", avail_cnt, 3);
        check("R10 data", pop_data, 60);
        check("R10 valid", pop_valid, 1);
        check("R9 req dropped", dma_req, 0);
        cfg_thresh = 5'd1; #0.5;
        check("R9 req above lower thr", dma_req, 1);
        dma_ack = 1'b1; step();
        check("R10 second ack", avail_cnt, 2);
        check("R10 second data", pop_data, 61);
        step(); step(); dma_ack = 1'b0;
        check("R10 emptied", avail_cnt, 0);
        check("R9 no req empty", dma_req, 0);
        check("R4 no unf yet", unf_flag, 0);
        dma_ack = 1'b1; step(); dma_ack = 1'b0;
        check("R4 ack on empty", unf_flag, 1);
        check("R4 ack on empty no data", pop_valid, 0);

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule